// File: doc/BRIEF.md
# SMRAM Access Decode and Router

This block decides where each memory request that falls inside the system-management RAM window should go. There are three possible verdicts: the local SMM DRAM, the downstream I/O link, or an abort. The decision uses a small control register with four bits: global enable, open, close and lock. It also uses qualifiers carried by each request: whether the processor issued it, whether it is a code fetch or a data access, whether it is a write, whether it is a cache writeback, and whether the processor is in system-management mode.

A request is accepted through a valid/ready handshake. One clock later the verdict appears on a registered response slot. The slot holds the verdict until the consumer takes it. A new request is accepted only when the slot is empty or is being emptied in the same cycle.

The window is a single base/size range, fixed by parameters. Setting the lock bit freezes the whole control register until reset. After that, only accesses made in SMM mode, or processor writebacks, can reach SMM DRAM.

Top module: `smram_router`

## Requirements
- R1: A request whose address is outside the window [WIN_BASE, WIN_BASE+WIN_SIZE) gets the verdict 2'b00 (forward to the downstream link).
- R2: While the enable bit (cfg bit 0) is clear, every request inside the window gets 2'b00.
- R3: With enable set, an in-window request from a non-processor source (req_cpu=0) gets 2'b10 (abort) and never 2'b01.
- R4: With enable set, an in-window processor request with both req_wb and req_write high gets 2'b01 (SMM DRAM), whatever the other bits are.
- R5: With enable set, a processor request in SMM mode (req_smm=1) gets 2'b01 if it is a code fetch (req_code=1). If it is a data access, it gets 2'b00 when close (cfg bit 2) is set and 2'b01 otherwise.
- R6: With enable set and lock clear, a processor request outside SMM mode gets 2'b00 when open (cfg bit 1) is clear. When open is set, it is routed as in R5.
- R7: With enable and lock (cfg bit 3) both set, a processor request outside SMM mode that is not a writeback gets 2'b00, whatever open is.
- R8: Before lock is set, a write on cfg_we loads all four cfg bits {lock, close, open, enable} (bits 3..0). Once lock reads 1, later writes leave cfg_rdata unchanged until reset.
- R9: cfg_illegal is high exactly while open and close are both set in the register.
- R10: A request accepted at a clock edge (req_valid and req_ready both high) appears on rsp_valid/rsp_route after that same edge. While rsp_valid=1 and rsp_ready=0, rsp_route holds. req_ready equals (!rsp_valid || rsp_ready).
- R11: After reset, cfg_rdata is 0, cfg_illegal is 0 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control write data {lock, close, open, enable} |
| cfg_rdata | output | 4 | Current control register value |
| cfg_illegal | output | 1 | Open and close both set |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Request address |
| req_cpu | input | 1 | 1 = processor source, 0 = I/O link source |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wb | input | 1 | Writeback qualifier (effective only with req_write) |
| req_smm | input | 1 | Processor is in SMM mode |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_route | output | 2 | 00 forward, 01 SMM DRAM, 10 abort |

## Verification
Every verdict is due exactly one edge after the edge that accepted its request. A control write takes effect at the edge where it is issued, so the next accepted request already sees the new value. The bench keeps a cycle model that applies the same one-edge rule to acceptance, holding and control writes. It compares every port at the falling edge, half a period after each update, so every output is stable when it is read. The stimulus sweeps all sixteen control values. For each one it holds a request until acceptance, so that each of the 32 qualifier patterns is actually routed. It then tries to rewrite the register after lock is set.

// File: rtl/smram_pkg.sv
package smram_pkg;

  typedef enum logic [1:0] {
    ROUTE_FWD   = 2'b00,
    ROUTE_DRAM  = 2'b01,
    ROUTE_ABORT = 2'b10
  } route_e;

  // bit 3 lock, bit 2 close, bit 1 open, bit 0 enable
  typedef struct packed {
    logic lock;
    logic close;
    logic open;
    logic enable;
  } smram_ctl_t;

  typedef struct packed {
    logic cpu;
    logic code;
    logic write;
    logic wb;
    logic smm;
  } smram_qual_t;

endpackage

// File: rtl/smram_rst_sync.sv
module smram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/smram_ctl_reg.sv
module smram_ctl_reg
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  smram_ctl_t wr_data,
  output smram_ctl_t ctl,
  output logic       illegal
);
  smram_ctl_t ctl_q, ctl_d;
  logic       ctl_upd;

  // once locked the whole register is frozen
  always_comb begin
    ctl_upd = wr_en && !ctl_q.lock;
    ctl_d   = ctl_q;
    if (ctl_upd) ctl_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= '0;
    else if (ctl_upd) ctl_q <= ctl_d;
  end

  assign ctl     = ctl_q;
  assign illegal = ctl_q.open & ctl_q.close;

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |=> (ctl_q.lock && $stable(ctl_q)));

endmodule

// File: rtl/smram_decode.sv
module smram_decode
  import smram_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0002_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  smram_qual_t       qual,
  input  smram_ctl_t        ctl,
  output logic              hit,
  output route_e            route
);
  localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

  logic wb_eff, open_eff, priv, data_to_link, dram_ok;

  always_comb begin
    hit          = ({1'b0, addr} >= {1'b0, WIN_BASE}) && ({1'b0, addr} < WIN_END);
    wb_eff       = qual.wb & qual.write;
    open_eff     = ctl.open & ~ctl.lock;          // lock cancels open
    priv         = qual.smm | open_eff;
    data_to_link = ctl.close & ~qual.code;        // close sends data out
    dram_ok      = wb_eff | (priv & ~data_to_link);

    if (!hit || !ctl.enable) route = ROUTE_FWD;
    else if (!qual.cpu)      route = ROUTE_ABORT;
    else if (dram_ok)        route = ROUTE_DRAM;
    else                     route = ROUTE_FWD;
  end
endmodule

// File: rtl/smram_out_slot.sv
module smram_out_slot #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         valid_q, valid_d;
  logic [W-1:0] data_q;
  logic         load;

  always_comb begin
    in_ready = !valid_q || out_ready;
    load     = in_valid && in_ready;
    valid_d  = valid_q;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // data path: enable only, no reset needed
  always_ff @(posedge clk) begin
    if (load) data_q <= in_data;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/smram_router.sv
module smram_router
  import smram_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE    = 32'h0002_0000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  output logic [3:0]        cfg_rdata,
  output logic              cfg_illegal,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cpu,
  input  logic              req_code,
  input  logic              req_write,
  input  logic              req_wb,
  input  logic              req_smm,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_route
);
  localparam int ROUTE_W = $bits(route_e);

  logic        rst_n_s;
  smram_ctl_t  ctl;
  smram_qual_t qual;
  logic        hit;
  route_e      route;
  logic [ROUTE_W-1:0] slot_out;

  smram_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  smram_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n_s), .wr_en(cfg_we), .wr_data(smram_ctl_t'(cfg_wdata)),
    .ctl(ctl), .illegal(cfg_illegal)
  );

  assign qual = '{cpu: req_cpu, code: req_code, write: req_write, wb: req_wb, smm: req_smm};

  smram_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_dec (
    .addr(req_addr), .qual(qual), .ctl(ctl), .hit(hit), .route(route)
  );

  smram_out_slot #(.W(ROUTE_W)) u_slot (
    .clk(clk), .rst_n(rst_n_s),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(route),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(slot_out)
  );

  assign rsp_route = slot_out;
  assign cfg_rdata = ctl;

  logic fire;
  assign fire = req_valid && req_ready;

  a_r1_outside_fwd: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fire && !hit) |=> (rsp_route == ROUTE_FWD));

  a_r2_disabled_fwd: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fire && !ctl.enable) |=> (rsp_route == ROUTE_FWD));

  a_r3_io_abort: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fire && hit && ctl.enable && !req_cpu) |=> (rsp_route == ROUTE_ABORT));

  a_r4_wb_dram: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fire && hit && ctl.enable && req_cpu && req_wb && req_write) |=> (rsp_route == ROUTE_DRAM));

endmodule

// File: tb/smram_router_tb_top.sv
module smram_router_tb_top;
  localparam logic [31:0] BASE = 32'h000A_0000;
  localparam logic [31:0] SIZE = 32'h0002_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] cfg_rdata;
  logic cfg_illegal;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_addr = '0;
  logic req_cpu = 1'b0, req_code = 1'b0, req_write = 1'b0, req_wb = 1'b0, req_smm = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [1:0] rsp_route;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  smram_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_illegal(cfg_illegal),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cpu(req_cpu), .req_code(req_code), .req_write(req_write),
    .req_wb(req_wb), .req_smm(req_smm),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_route(rsp_route)
  );

  // reference verdict straight from the requirements
  function automatic logic [1:0] ref_route(input logic [3:0] c, input logic [31:0] a,
      input logic cpu, code, wr, wb, smm, output string tag);
    logic in_win;
    in_win = (a >= BASE) && (a < BASE + SIZE);
    if (!in_win)          begin tag = "R1"; return 2'b00; end
    if (!c[0])            begin tag = "R2"; return 2'b00; end
    if (!cpu)             begin tag = "R3"; return 2'b10; end
    if (wb && wr)         begin tag = "R4"; return 2'b01; end
    if (smm)              begin tag = "R5"; return (code || !c[2]) ? 2'b01 : 2'b00; end
    if (c[3])             begin tag = "R7"; return 2'b00; end
    tag = "R6";
    if (!c[1]) return 2'b00;
    return (code || !c[2]) ? 2'b01 : 2'b00;
  endfunction

  // cycle model; the synchronised reset is released a couple of cycles late,
  // stimulus waits for that, so the model resets from the pin
  logic [3:0] m_cfg;
  logic       m_valid;
  logic [1:0] m_route;
  string      m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg <= '0; m_valid <= 1'b0; m_route <= '0; m_tag <= "R10";
    end else begin
      if (req_valid && (!m_valid || rsp_ready)) begin
        string t;
        m_route <= ref_route(m_cfg, req_addr, req_cpu, req_code, req_write, req_wb, req_smm, t);
        m_tag   <= t;
        m_valid <= 1'b1;
      end else if (rsp_ready) begin
        m_valid <= 1'b0;
      end
      if (cfg_we && !m_cfg[3]) m_cfg <= cfg_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every port on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_valid});
      chk("R10 req_ready", {31'b0, req_ready}, {31'b0, (!m_valid || rsp_ready)});
      chk("R8 cfg_rdata", {28'b0, cfg_rdata}, {28'b0, m_cfg});
      chk("R9 cfg_illegal", {31'b0, cfg_illegal}, {31'b0, (m_cfg[1] & m_cfg[2])});
      if (m_valid) chk(m_tag, {30'b0, rsp_route}, {30'b0, m_route});
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    // R11: reset state visible at the ports
    chk("R11 cfg_rdata", {28'b0, cfg_rdata}, 32'd0);
    chk("R11 cfg_illegal", {31'b0, cfg_illegal}, 32'd0);
    chk("R11 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  int rr = 0;
  task automatic send(input logic [31:0] a, input logic [4:0] q);
    req_valid = 1'b1; req_addr = a;
    {req_cpu, req_code, req_write, req_wb, req_smm} = q;
    forever begin
      rr++;
      rsp_ready = (rr % 3) != 0;
      #1;
      if (req_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 16; c++) begin
      do_reset();
      write_cfg(4'(c));
      for (int k = 0; k < 32; k++) begin
        send(BASE + 32'(k * 64), 5'(k));           // R2..R7 sweep
      end
      send(BASE - 32'd1, 5'b11001);                 // R1 below window
      send(BASE + SIZE, 5'b11001);                  // R1 at window end
      send(BASE + SIZE - 32'd1, 5'b10000);          // last in-window byte
      // R8: rewrite attempts; ignored when locked, applied otherwise
      write_cfg(~4'(c) & 4'b0111);
      write_cfg(4'b0000);
      send(BASE + 32'h40, 5'b10100);
      rsp_ready = 1'b1;
      repeat (2) @(negedge clk);
    end
    // R8: locking write followed by attempts to unlock
    do_reset();
    write_cfg(4'b0011);
    write_cfg(4'b1101);
    write_cfg(4'b0000);
    write_cfg(4'b0111);
    send(BASE, 5'b10000);                           // R7 locked, non-SMM data
    send(BASE, 5'b11001);                           // R5 locked, SMM code
    // R10: hold verdict with ready low
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = BASE; {req_cpu, req_code, req_write, req_wb, req_smm} = 5'b00000;
    repeat (4) @(negedge clk);
    req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule